// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous serial frame on a single output line. The frame starts with one low start bit and carries 5 to 8 data bits, least significant bit first. An optional parity bit follows the data, and a high stop period of half, one, one and a half or two bit periods ends the frame. The line sits high whenever no frame is being sent.

Bit timing comes from an oversampling enable, `tick`, which an external divider drives. Each bit period is `OVS` ticks long (16 by default), so a half-bit stop lasts 8 ticks. A character is offered on `tx_data` with a `tx_valid`/`tx_ready` handshake. The character and the configuration inputs are captured together when the handshake completes. While the frame is in progress, changes on those inputs have no effect. `done` pulses for one clock in the final cycle of the stop period.

The controller is a five-state machine:
- IDLE moves to START when a character is accepted.
- START moves to DATA at the end of the start bit.
- DATA stays in DATA after each data bit except the last.
- After the last data bit, DATA moves to PARITY if parity is enabled, or to STOP if it is not.
- PARITY moves to STOP at the end of the parity bit.
- STOP moves back to IDLE once the programmed stop ticks have elapsed.

Top module: `uline_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `tx_ready` is 1 and `done` is 0.
- R2: A character is accepted on a rising clock edge where both `tx_valid` and `tx_ready` are 1. `tx_ready` is 0 from the next cycle until the cycle after the stop period ends.
- R3: After acceptance, `txd` is 0 for 16 ticks (the start bit). Each data bit then follows, least significant bit first, for 16 ticks each.
- R4: `cfg_size` selects the data bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above that count are not sent, even when they are nonzero.
- R5: When `cfg_par_en` is 1, one parity bit of 16 ticks is sent directly after the most significant data bit. With `cfg_par_odd` at 0 (even parity), the ones in the data bits plus the parity bit add up to an even number. With `cfg_par_odd` at 1 (odd parity), they add up to an odd number.
- R6: When `cfg_par_en` is 0, the stop period follows the last data bit directly.
- R7: The stop period holds `txd` high. Its length depends on `cfg_stop`: 0 gives 8 ticks, 1 gives 16, 2 gives 24 and 3 gives 32.
- R8: `done` is 1 for exactly one cycle, the last cycle of the stop period, and `tx_ready` is 1 in the cycle after it.
- R9: While `tick` is 0 during a frame, the frame does not advance and `txd` holds its value.
- R10: `tx_valid` and `tx_data` have no effect while a frame is in progress; the character being sent is not altered.
- R11: Changes on `cfg_stop`, `cfg_size`, `cfg_par_en` and `cfg_par_odd` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, OVS per bit period |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter can accept a character |
| tx_data | input | 8 | Character, bit 0 sent first |
| cfg_stop | input | 2 | Stop length: 0 half, 1 one, 2 one and a half, 3 two bit periods |
| cfg_size | input | 2 | Data bits: 0..3 select 5..8 |
| cfg_par_en | input | 1 | Parity bit inserted when 1 |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| txd | output | 1 | Serial line, idles high |
| done | output | 1 | One-cycle pulse in the last stop cycle |

## Verification
With `tick` held high, count clock cycles from the acceptance edge. The line takes the start value one cycle after that edge. Slot k (start, then data, then parity) covers cycles 16k to 16k+15. The stop period follows, and `done` is due in cycle 16·slots + stop_ticks − 1, with `tx_ready` back one cycle later. Each frame task builds the expected slot list from the data and configuration. It then compares `txd`, `done` and `tx_ready` on every falling edge against the cycle index. In the stall scenario, the cycle index stops while `tick` is low and starts again from the first ticked edge.

// File: rtl/ulx_pkg.sv
package ulx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } ulx_state_e;

    typedef struct packed {
        logic [1:0] stop_sel;
        logic [1:0] size_sel;
        logic       par_en;
        logic       par_odd;
    } ulx_cfg_t;

endpackage

// File: rtl/ulx_tick_timer.sv
module ulx_tick_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ulx_char_shift.sv
module ulx_char_shift
    import ulx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CHAR_W-1:0] data,
    input  logic              par_odd,
    output logic              lsb,
    output logic              par_bit
);

    logic [CHAR_W-1:0] sh_q;
    logic              acc_q;

    // The accumulator starts at the parity sense and folds in each bit as it leaves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            acc_q <= 1'b0;
        end else if (load) begin
            sh_q  <= data;
            acc_q <= par_odd;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[CHAR_W-1:1]};
            acc_q <= acc_q ^ sh_q[0];
        end
    end

    assign lsb     = sh_q[0];
    assign par_bit = acc_q;

endmodule

// File: rtl/ulx_tx_fsm.sv
module ulx_tx_fsm
    import ulx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tx_valid,
    input  ulx_cfg_t         cfg_in,
    input  logic             lsb,
    input  logic             par_bit,
    output logic             load,
    output logic             shift,
    output logic             clr,
    output logic             tx_ready,
    output logic             done,
    output logic             txd
);

    localparam int HALF = OVS / 2;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

    ulx_state_e       state_q, state_nx;
    ulx_cfg_t         cfg_q;
    logic [2:0]       idx_q;
    logic [2:0]       idx_last;
    logic [CNT_W-1:0] stop_last;
    logic             bit_end;
    logic             adv;

    assign idx_last  = {1'b0, cfg_q.size_sel} + 3'd4;
    assign stop_last = CNT_W'((int'(cfg_q.stop_sel) + 1) * HALF - 1);
    assign bit_end   = tick && (cnt == BIT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (load) begin
                cfg_q <= cfg_in;
                idx_q <= '0;
            end else if (shift) begin
                idx_q <= idx_q + 3'd1;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        shift    = 1'b0;
        adv      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_valid) begin
                    load     = 1'b1;
                    state_nx = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    adv      = 1'b1;
                    state_nx = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    adv   = 1'b1;
                    shift = 1'b1;
                    if (idx_q == idx_last) begin
                        state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    adv      = 1'b1;
                    state_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick && (cnt == stop_last)) begin
                    adv      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clr      = adv || (state_q == ST_IDLE);
        tx_ready = (state_q == ST_IDLE);
        done     = (state_q == ST_STOP) && adv;
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = lsb;
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uline_tx.sv
module uline_tx
    import ulx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic [1:0]        cfg_stop,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              txd,
    output logic              done
);

    localparam int CNT_W = $clog2(2 * OVS);

    ulx_cfg_t         cfg_w;
    logic [CNT_W-1:0] cnt;
    logic             load, shift, clr, lsb, par_bit;

    assign cfg_w = '{stop_sel: cfg_stop, size_sel: cfg_size,
                     par_en: cfg_par_en, par_odd: cfg_par_odd};

    ulx_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .cnt(cnt)
    );

    ulx_char_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .data(tx_data), .par_odd(cfg_par_odd), .lsb(lsb), .par_bit(par_bit)
    );

    ulx_tx_fsm #(.OVS(OVS), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
        .tx_valid(tx_valid), .cfg_in(cfg_w), .lsb(lsb), .par_bit(par_bit),
        .load(load), .shift(shift), .clr(clr),
        .tx_ready(tx_ready), .done(done), .txd(txd)
    );

endmodule

// File: rtl/uline_tx_chk.sv
module uline_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic done
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (txd && !done));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !txd);

    // R7
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txd);

    // R8
    done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tx_ready && !done));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !tx_ready) |=> ($stable(txd) && !tx_ready));

endmodule

bind uline_tx uline_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .done(done)
);

// File: tb/sim_uline_tx.sv
`timescale 1ns/1ps
module sim_uline_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic [1:0] cfg_stop = 2'd1;
    logic [1:0] cfg_size = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       txd;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uline_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .cfg_stop(cfg_stop),
        .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .txd(txd), .done(done)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd === 1'b1 && tx_ready === 1'b1 && done === 1'b0,
            $sformatf("R1 idle outputs txd/ready/done actual %b%b%b expected 110",
                      txd, tx_ready, done));
    endtask

    // One frame: stall = ticks withheld after acceptance, disturb = change inputs mid-frame.
    task automatic run_frame(input logic [7:0] d, input logic [1:0] sz, input logic [1:0] st,
                             input logic pe, input logic po, input int stall,
                             input bit disturb, input string tag);
        logic slot [0:10];
        logic [7:0] mask;
        int nb, total, c0, bad_tx, bad_done, bad_rdy, first_c;
        logic exp_v, act_v;
        mask = 8'hFF >> (3 - sz);
        slot[0] = 1'b0;
        for (int i = 0; i < int'(sz) + 5; i++) slot[1 + i] = d[i];
        nb = int'(sz) + 6;
        if (pe) begin
            slot[nb] = (^(d & mask)) ^ po;
            nb++;
        end
        total = 16 * nb + 8 * (int'(st) + 1);
        bad_tx = 0; bad_done = 0; bad_rdy = 0; first_c = -1;
        exp_v = 1'b0; act_v = 1'b0;

        @(negedge clk);
        cfg_stop = st; cfg_size = sz; cfg_par_en = pe; cfg_par_odd = po;
        tx_data = d; tx_valid = 1'b1; tick = (stall == 0);
        chk(tx_ready === 1'b1, $sformatf("R2 %s ready before accept actual %b expected 1", tag, tx_ready));
        @(negedge clk);
        tx_valid = 1'b0;
        c0 = 0;
        if (stall > 0) begin
            int hold_bad;
            hold_bad = 0;
            for (int s = 0; s < stall; s++) begin
                if (txd !== 1'b0 || tx_ready !== 1'b0) hold_bad++;
                @(negedge clk);
            end
            chk(hold_bad == 0, $sformatf("R9 %s line/ready moved without tick: %0d bad cycles expected 0",
                                         tag, hold_bad));
            tick = 1'b1;
            @(negedge clk);
            c0 = 1;
        end
        for (int c = c0; c < total; c++) begin
            exp_v = (c < 16 * nb) ? slot[c / 16] : 1'b1;
            if (txd !== exp_v) begin
                if (first_c < 0) begin
                    first_c = c; act_v = txd;
                end
                bad_tx++;
            end
            if (done !== (c == total - 1)) bad_done++;
            if (tx_ready !== 1'b0) bad_rdy++;
            if (disturb && c == 20) begin
                tx_valid = 1'b1; tx_data = ~d;
                cfg_stop = ~st; cfg_size = ~sz; cfg_par_en = ~pe; cfg_par_odd = ~po;
            end
            if (disturb && c == total - 1) tx_valid = 1'b0;
            @(negedge clk);
        end
        chk(bad_tx == 0, $sformatf("%s txd waveform: %0d bad cycles, first at %0d actual %b expected %b",
                                   tag, bad_tx, first_c, act_v,
                                   (first_c < 16 * nb && first_c >= 0) ? slot[first_c / 16] : 1'b1));
        chk(bad_done == 0, $sformatf("R8 %s done pulse: %0d bad cycles expected 0", tag, bad_done));
        chk(bad_rdy == 0, $sformatf("R2 %s ready during frame: %0d bad cycles expected 0", tag, bad_rdy));
        chk(tx_ready === 1'b1 && txd === 1'b1 && done === 1'b0,
            $sformatf("R8 R1 %s after stop ready/txd/done actual %b%b%b expected 110",
                      tag, tx_ready, txd, done));
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        run_frame(8'hA5, 2'd3, 2'd1, 1'b0, 1'b0, 0, 1'b0, "R3 R6 R7 8N1");
        run_frame(8'hF3, 2'd0, 2'd1, 1'b0, 1'b0, 0, 1'b0, "R4 five-bit");
        run_frame(8'h2A, 2'd1, 2'd3, 1'b0, 1'b0, 0, 1'b0, "R4 R7 six-bit two-stop");
        run_frame(8'h55, 2'd2, 2'd1, 1'b1, 1'b0, 0, 1'b0, "R4 R5 seven-bit even");
        run_frame(8'hA5, 2'd3, 2'd2, 1'b1, 1'b1, 0, 1'b0, "R5 R7 odd stop1.5");
        run_frame(8'h00, 2'd3, 2'd0, 1'b0, 1'b0, 0, 1'b0, "R7 half stop");
        run_frame(8'hFF, 2'd3, 2'd1, 1'b1, 1'b0, 0, 1'b0, "R5 even all ones");
        run_frame(8'h3C, 2'd3, 2'd1, 1'b0, 1'b0, 20, 1'b0, "R9 stall");
        run_frame(8'h81, 2'd3, 2'd1, 1'b1, 1'b1, 0, 1'b1, "R10 R11 busy ignore");
        run_frame(8'h0B, 2'd0, 2'd0, 1'b1, 1'b1, 0, 1'b0, "R4 R5 R6 five-bit odd");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule